// File: doc/BRIEF.md
# Fast External Interrupt Source Selector with Programmable Edge Detect

This block sits in front of an interrupt controller and turns eight asynchronous request lines into clean, single-cycle request pulses. Each channel takes a port pin and, for the lower four channels, an internal alternate signal: two serial-bus receive lines, a periodic timer event and a timer alarm. A 2-bit source field per channel chooses the pin alone, the alternate alone, or the logical OR or AND of the two. The upper four channels have no alternate signal, so it reads as constant zero there.

The chosen signal passes through a two-flop synchronizer. An edge detector then fires on a rising edge, a falling edge or both, set by a separate 2-bit mode field per channel. Both fields live in two 16-bit configuration words. Channel x uses bits [2x+1:2x] in each word. Rewriting a channel's source field can make the combined signal jump even though no real event happened. To avoid a false request, the edge detector of that channel is blanked for the one cycle in which the jump reaches it.

Top module: `xirq_src_edge`

## Requirements
- R1: While `rst` is high at a clock edge, every source field returns to 0 (pin only), every mode field returns to 00 (detection off) and `irq_pulse` is cleared. With all modes at 00, no pulse is ever produced.
- R2: Source field value 0 makes the channel follow its port pin `pin_in[x]` only.
- R3: Source field value 1 makes the channel follow its alternate input only. For channels 0 to 3 this is `alt_in[x]`.
- R4: Source field value 2 makes the channel follow `pin_in[x] | alt`.
- R5: Source field value 3 makes the channel follow `pin_in[x] & alt`.
- R6: Channel x takes its source field from `sel_wdata[2x+1:2x]` and its mode field from `mode_wdata[2x+1:2x]`. A word is loaded on the clock edge where its write strobe is high.
- R7: Mode field values: 01 detects rising edges only, 10 detects falling edges only, 11 detects both, and 00 detects nothing.
- R8: The combined signal is sampled at clock edge k. If its value then differs from its value at edge k-1 and the mode allows that direction, `irq_pulse[x]` is high for exactly the cycle after edge k+2.
- R9: Suppose a source write at edge T changes channel x's field. Then `irq_pulse[x]` stays low after edge T+3, which is the edge where the change would show. Channels whose field is unchanged keep their normal pulses.
- R10: Channels 4 to 7 have a constant-zero alternate. Source 1 or 3 never pulses there, and source 2 behaves like source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load strobe for the source-select word |
| sel_wdata | input | 16 | Source-select word, 2 bits per channel |
| mode_we | input | 1 | Load strobe for the edge-mode word |
| mode_wdata | input | 16 | Edge-mode word, 2 bits per channel |
| pin_in | input | 8 | Asynchronous port pin requests |
| alt_in | input | 4 | Asynchronous alternate sources for channels 0 to 3 |
| irq_pulse | output | 8 | Registered one-cycle request pulses, one per channel |

## Verification
The source combinations are tested by holding pins and alternates in each of the four joint states while sweeping the source field. This separates pin-only, alternate-only, OR and AND: for each mode there is a pattern where it alone toggles the output. Rising-only, falling-only and both-edge modes are driven with the same pin waveform, so the difference between them shows as missing or extra pulses. Directed cases cover three things: the exact three-cycle latency, a source rewrite that flips the combined level while a neighbouring channel sees a real edge at the same time, and the zero-alternate upper channels. Long random runs then mix writes and input toggles against a cycle-level model in the bench.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    SRC_PIN = 2'd0,
    SRC_ALT = 2'd1,
    SRC_OR  = 2'd2,
    SRC_AND = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  function automatic logic src_combine(input src_sel_e sel, input logic pin, input logic alt);
    logic r;
    case (sel)
      SRC_PIN: r = pin;
      SRC_ALT: r = alt;
      SRC_OR:  r = pin | alt;
      default: r = pin & alt;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs #(
  parameter int N_CH = 8,
  localparam int CFG_W = 2 * N_CH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [CFG_W-1:0] sel_wdata,
  input  logic             mode_we,
  input  logic [CFG_W-1:0] mode_wdata,
  output logic [CFG_W-1:0] sel_q,
  output logic [CFG_W-1:0] mode_q,
  output logic [N_CH-1:0]  sel_chg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      mode_q <= '0;
    end else begin
      if (sel_we)  sel_q  <= sel_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  // a channel is flagged only when its own field actually changes
  for (genvar g = 0; g < N_CH; g++) begin : g_chg
    assign sel_chg[g] = sel_we && (sel_wdata[2*g +: 2] != sel_q[2*g +: 2]);
  end

endmodule

// File: rtl/xirq_src_mux.sv
module xirq_src_mux
  import xirq_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       pin,
  input  logic       alt,
  output logic       comb
);

  assign comb = src_combine(src_sel_e'(sel), pin, alt);

endmodule

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/xirq_edge_det.sv
module xirq_edge_det #(
  parameter int BLANK_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [1:0] mode,
  input  logic       chg,
  output logic       pulse
);

  logic                 prev;
  logic [BLANK_LEN-1:0] blk;
  logic                 rise, fall, hit;

  assign rise = din & ~prev;
  assign fall = ~din & prev;
  // mode bit 0 enables rising, bit 1 enables falling
  assign hit  = (rise & mode[0]) | (fall & mode[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      blk   <= '0;
      pulse <= 1'b0;
    end else begin
      prev  <= din;
      blk   <= {blk[BLANK_LEN-2:0], chg};
      pulse <= hit & ~blk[BLANK_LEN-1];
    end
  end

endmodule

// File: rtl/xirq_src_edge.sv
module xirq_src_edge #(
  parameter int N_CH        = 8,
  parameter int N_ALT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_we,
  input  logic [2*N_CH-1:0]   sel_wdata,
  input  logic                mode_we,
  input  logic [2*N_CH-1:0]   mode_wdata,
  input  logic [N_CH-1:0]     pin_in,
  input  logic [N_ALT-1:0]    alt_in,
  output logic [N_CH-1:0]     irq_pulse
);

  localparam int CFG_W     = 2 * N_CH;
  localparam int BLANK_LEN = SYNC_STAGES + 1;

  logic [CFG_W-1:0] sel_q, mode_q;
  logic [N_CH-1:0]  sel_chg, alt_vec, comb_vec, sync_vec;

  xirq_cfg_regs #(.N_CH(N_CH)) u_cfg (
    .clk(clk), .rst(rst),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .sel_q(sel_q), .mode_q(mode_q), .sel_chg(sel_chg)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    if (g < N_ALT) begin : g_alt
      assign alt_vec[g] = alt_in[g];
    end else begin : g_noalt
      assign alt_vec[g] = 1'b0;
    end

    xirq_src_mux u_mux (
      .sel(sel_q[2*g +: 2]), .pin(pin_in[g]), .alt(alt_vec[g]), .comb(comb_vec[g])
    );

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(comb_vec[g]), .q(sync_vec[g])
    );

    xirq_edge_det #(.BLANK_LEN(BLANK_LEN)) u_edge (
      .clk(clk), .rst(rst), .din(sync_vec[g]),
      .mode(mode_q[2*g +: 2]), .chg(sel_chg[g]), .pulse(irq_pulse[g])
    );
  end

endmodule

// File: rtl/xirq_src_edge_chk.sv
module xirq_src_edge_chk #(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_we,
  input logic [2*N_CH-1:0] sel_wdata,
  input logic [2*N_CH-1:0] sel_q,
  input logic [2*N_CH-1:0] mode_q,
  input logic [N_CH-1:0]   irq_pulse
);

  // R1: reset clears configuration and outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irq_pulse == '0 && sel_q == '0 && mode_q == '0));

  // R6: a strobed word is taken whole
  assert_sel_load_R6: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> (sel_q == $past(sel_wdata)));

  for (genvar g = 0; g < N_CH; g++) begin : g_p
    // R7: no pulse while the channel's mode was off
    assert_mode_gate_R7: assert property (@(posedge clk) disable iff (rst)
      irq_pulse[g] |-> ($past(mode_q[2*g +: 2]) != 2'b00));

    // R9: a field rewrite blanks the cycle where its effect arrives
    assert_rewrite_blank_R9: assert property (@(posedge clk) disable iff (rst)
      $past(sel_we && (sel_wdata[2*g +: 2] != sel_q[2*g +: 2]), SYNC_STAGES + 2)
      |-> !irq_pulse[g]);
  end

endmodule

bind xirq_src_edge xirq_src_edge_chk #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
  .sel_q(sel_q), .mode_q(mode_q), .irq_pulse(irq_pulse)
);

// File: tb/sim_xirq_src_edge.sv
module sim_xirq_src_edge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_we = 1'b0, mode_we = 1'b0;
  logic [15:0] sel_wdata = '0, mode_wdata = '0;
  logic [7:0]  pin_in = '0;
  logic [3:0]  alt_in = '0;
  logic [7:0]  irq_pulse;

  int total = 0, bad = 0;
  string phase = "R1";
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  xirq_src_edge u0 (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .pin_in(pin_in), .alt_in(alt_in), .irq_pulse(irq_pulse)
  );

  // source combination from R2..R5, alternate zero above channel 3 (R10)
  function automatic logic exp_comb(input logic [1:0] s, input logic p, input logic a);
    case (s)
      2'd0: return p;
      2'd1: return a;
      2'd2: return p | a;
      default: return p & a;
    endcase
  endfunction

  // cycle model following R1, R6, R7, R8, R9
  logic [7:0]  p1, p2, p3, b1, b2, b3, exp_m;
  logic [15:0] sel_m, mode_m;

  always @(posedge clk) begin
    logic [7:0] cn, chg;
    if (rst) begin
      p1 = '0; p2 = '0; p3 = '0; b1 = '0; b2 = '0; b3 = '0;
      sel_m = '0; mode_m = '0; exp_m = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic a;
        exp_m[i] = ((p2[i] & ~p3[i] & mode_m[2*i]) | (~p2[i] & p3[i] & mode_m[2*i+1])) & ~b3[i];
        a = (i < 4) ? alt_in[i] : 1'b0;
        cn[i]  = exp_comb(sel_m[2*i +: 2], pin_in[i], a);
        chg[i] = sel_we && (sel_wdata[2*i +: 2] != sel_m[2*i +: 2]);
      end
      p3 = p2; p2 = p1; p1 = cn;
      b3 = b2; b2 = b1; b1 = chg;
      if (sel_we)  sel_m  = sel_wdata;
      if (mode_we) mode_m = mode_wdata;
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irq_pulse=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) check8(phase, irq_pulse, exp_m);
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_sel(input logic [15:0] v);
    sel_wdata = v; sel_we = 1'b1;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic write_mode(input logic [15:0] v);
    mode_wdata = v; mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    void'($urandom(32'd20240611));
    @(negedge clk);
    wait_n(3);
    check8("R1 reset output", irq_pulse, 8'h00);
    rst = 1'b0;
    model_on = 1'b1;

    // R1: modes default to off, pins toggle without pulses
    phase = "R1";
    acc = '0;
    for (int i = 0; i < 10; i++) begin
      pin_in = ~pin_in; @(negedge clk); acc |= irq_pulse;
    end
    check8("R1 no pulse with modes off", acc, 8'h00);

    // R8 latency, R7 rising only on channel 0 (R6 field 1:0)
    phase = "R8";
    pin_in = '0;
    write_mode(16'h0001);
    wait_n(4);
    pin_in[0] = 1'b1;
    @(negedge clk); check8("R8 latency cycle1", irq_pulse, 8'h00);
    @(negedge clk); check8("R8 latency cycle2", irq_pulse, 8'h00);
    @(negedge clk); check8("R8 pulse cycle3", irq_pulse, 8'h01);
    @(negedge clk); check8("R8 single cycle", irq_pulse, 8'h00);
    pin_in[0] = 1'b0;
    wait_n(4);
    phase = "R7";
    acc = '0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); acc |= irq_pulse; end
    check8("R7 falling ignored in rise mode", acc, 8'h00);

    // R7: falling only on channel 5 (R6 field 11:10)
    write_mode(16'h0800);
    pin_in[5] = 1'b1; wait_n(5);
    pin_in[5] = 1'b0;
    wait_n(2);
    @(negedge clk); check8("R7 fall pulse ch5", irq_pulse, 8'h20);

    // R9: rewrite of ch0 drops the combined level, ch1 sees a real edge
    phase = "R9";
    write_mode(16'hFFFF);
    write_sel(16'h0000);
    pin_in = 8'h01; alt_in = 4'h0;
    wait_n(6);
    sel_wdata = 16'h0001; sel_we = 1'b1; pin_in[1] = 1'b1;
    @(negedge clk); sel_we = 1'b0;
    acc = irq_pulse;
    @(negedge clk); acc |= irq_pulse;
    @(negedge clk); check8("R9 neighbour keeps pulse", irq_pulse & 8'h02, 8'h02);
    acc |= irq_pulse;
    @(negedge clk); acc |= irq_pulse;
    @(negedge clk); acc |= irq_pulse;
    check8("R9 rewritten channel blanked", acc & 8'h01, 8'h00);

    // R3/R4/R5 directed on channel 2: pin high, alt toggled
    phase = "R3";
    write_sel(16'h0010); pin_in = 8'h04; alt_in = 4'h0; wait_n(5);
    alt_in[2] = 1'b1; wait_n(2);
    @(negedge clk); check8("R3 alt-only follows alt", irq_pulse & 8'h04, 8'h04);
    phase = "R5";
    write_sel(16'h0030); wait_n(5);
    pin_in[2] = 1'b0; wait_n(2);
    @(negedge clk); check8("R5 AND falls with pin", irq_pulse & 8'h04, 8'h04);
    phase = "R4";
    write_sel(16'h0020); wait_n(5);
    pin_in[2] = 1'b1; acc = '0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); acc |= irq_pulse; end
    check8("R4 OR holds while alt high", acc & 8'h04, 8'h00);

    // R10: upper channels with zero alternate
    phase = "R10";
    write_sel(16'h5500); wait_n(5); acc = '0;
    for (int i = 0; i < 8; i++) begin pin_in[7:4] = ~pin_in[7:4]; @(negedge clk); acc |= irq_pulse; end
    wait_n(4);
    check8("R10 alt-only silent", acc & 8'hF0, 8'h00);
    write_sel(16'hFF00); wait_n(5); acc = '0;
    for (int i = 0; i < 8; i++) begin pin_in[7:4] = ~pin_in[7:4]; @(negedge clk); acc |= irq_pulse; end
    wait_n(4);
    check8("R10 AND silent", acc & 8'hF0, 8'h00);
    write_sel(16'hAA00); wait_n(5); acc = '0;
    pin_in[7:4] = ~pin_in[7:4];
    wait_n(2); @(negedge clk);
    check8("R10 OR acts as pin", irq_pulse & 8'hF0, 8'hF0);

    // R2..R6: random mix checked by the model every cycle
    phase = "R2-mix";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 3) == 0) pin_in = 8'($urandom);
      if (($urandom % 3) == 0) alt_in = 4'($urandom);
      if (($urandom % 16) == 0) begin sel_wdata = 16'($urandom); sel_we = 1'b1; end
      else sel_we = 1'b0;
      if (($urandom % 20) == 0) begin mode_wdata = 16'($urandom); mode_we = 1'b1; end
      else mode_we = 1'b0;
      @(negedge clk);
    end
    sel_we = 1'b0; mode_we = 1'b0;

    // R1: reset mid-run clears configuration
    phase = "R1";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check8("R1 reset clears pulses", irq_pulse, 8'h00);
    acc = '0;
    for (int i = 0; i < 8; i++) begin pin_in = ~pin_in; @(negedge clk); acc |= irq_pulse; end
    check8("R1 modes off after reset", acc, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule